// File: doc/BRIEF.md
# Event Performance Counter Bank

This block is a bank of event counters placed behind a simple 32-bit register bus with separate read and write strobes. Each counter picks one of a set of event input lines through its own event selector, and adds one on every clock in which that line is high. A counter advances only while three conditions hold together: the global enable, the enable of the group the counter belongs to, and the counter's own enable. Counters are split evenly into groups in index order, so counter n belongs to group n / (counters per group).

Software switches counter enables and overflow-interrupt enables through paired write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. A counter that wraps from all-ones to zero raises its overflow status bit. The status register is write-one-to-clear. A single interrupt output is raised whenever a status bit is set and its interrupt enable is also set. A configuration word tells software how many counters and groups the bank holds.

Byte address map (default parameters, 8 counters in 2 groups, 16 event lines): 0x000 main control; 0x004 configuration; 0x010 counter-enable set; 0x014 counter-enable clear; 0x018 interrupt-enable set; 0x01C interrupt-enable clear; 0x020 overflow status; 0x100 + 4*g group control; 0x200 + 4*n event selector; 0x300 + 4*n counter value. Bit n of the enable, interrupt-enable and status words belongs to counter n. Reads return data one clock after the read strobe.

Top module: `pmu_evt_bank`

## Requirements
- R1: After reset, every counter reads 0, the global enable (control bit 0) reads 0, all counter enables, interrupt enables and overflow bits read 0, and the interrupt output is low.
- R2: While control bit 0 is 0, no counter changes on event input.
- R3: Bit 11 of group control register g (address 0x100 + 4*g) enables counting for that group's counters; while it is 0 those counters hold.
- R4: Writing 1s to 0x010 turns the matching counter enables on, writing 1s to 0x014 turns them off, 0 bits leave a counter's enable as it was, and either address reads back the current enable word.
- R5: A counter whose three enables are on adds exactly 1 on each clock in which the event line chosen by its selector (bits 3:0 at 0x200 + 4*n) is high, and holds otherwise.
- R6: Writing a 1 to control bit 1 sets every counter to zero in that cycle; the bit reads back as 0 and the global enable takes bit 0 of the same write.
- R7: A counter that counts from all-ones to zero sets its bit in the overflow status word (0x020); writing a 1 to that bit clears it, and 0 bits leave it unchanged.
- R8: The interrupt output is high exactly when some overflow bit is set whose interrupt enable (set at 0x018, cleared at 0x01C) is also set.
- R9: When a wrap and a clearing write hit the same overflow bit in the same cycle, the bit ends up set.
- R10: The configuration word reports the counter count in bits 7:0 and the group count in bits 31:24, and each group control register reports its counter count in bits 27:24.
- R11: A write to 0x300 + 4*n loads counter n, and a read of that address returns its value on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| evt_in | input | 16 | Event input lines |
| irq | output | 1 | Overflow interrupt |

## Verification
A wrong enable bit or a misrouted group enable shows up as a counter value that differs from the count of selected event pulses on the next read of that counter, one clock after the read strobe. A lost or spurious overflow bit changes the interrupt output in the cycle after the wrap edge when the interrupt enable is set, and the status word on the next read otherwise. The wrap that coincides with a clearing write is driven on purpose, because a wrong priority there loses the overflow silently.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int GRP_EN_BIT   = 11;
    localparam int GRP_CNT_LSB  = 24;
    localparam int CFG_GRP_LSB  = 24;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_CFG,
        RG_ENSET,
        RG_ENCLR,
        RG_IESET,
        RG_IECLR,
        RG_OVF,
        RG_GRP,
        RG_SEL,
        RG_VAL
    } region_e;

    typedef struct packed {
        region_e           region;
        logic [IDX_W-1:0]  idx;
    } bus_dec_t;

    function automatic bus_dec_t pmu_decode(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        d.idx    = a[IDX_W+1:2];
        d.region = RG_NONE;
        case (a[11:8])
            4'h0: begin
                case (a[7:0])
                    8'h00: d.region = RG_CTRL;
                    8'h04: d.region = RG_CFG;
                    8'h10: d.region = RG_ENSET;
                    8'h14: d.region = RG_ENCLR;
                    8'h18: d.region = RG_IESET;
                    8'h1C: d.region = RG_IECLR;
                    8'h20: d.region = RG_OVF;
                    default: d.region = RG_NONE;
                endcase
            end
            4'h1: d.region = RG_GRP;
            4'h2: d.region = RG_SEL;
            4'h3: d.region = RG_VAL;
            default: d.region = RG_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 16,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               clr,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   value,
    output logic               wrap
);
    localparam int EXT_W = 1 << SEL_W;

    logic [EXT_W-1:0] evt_ext;
    logic             hit;

    assign evt_ext = EXT_W'(evt);
    assign hit     = active && evt_ext[sel];
    assign wrap    = hit && !clr && !load && (value == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (hit) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/pmu_regs.sv
module pmu_regs
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int NUM_GRP = 2,
    parameter int CNT_W   = 32,
    parameter int SEL_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_val,
    input  logic [NUM_CNT-1:0]                wrap,
    output logic [DATA_W-1:0]                 rdata,
    output logic                              glob_en,
    output logic [NUM_GRP-1:0]                grp_en,
    output logic [NUM_CNT-1:0]                cnt_en,
    output logic [NUM_CNT-1:0]                int_en,
    output logic [NUM_CNT-1:0]                ovf,
    output logic [NUM_CNT-1:0][SEL_W-1:0]     evsel,
    output logic                              clr_all,
    output logic [NUM_CNT-1:0]                load
);
    localparam int PER_GRP = NUM_CNT / NUM_GRP;

    bus_dec_t           dec;
    logic [NUM_CNT-1:0] w1c;
    logic [NUM_CNT-1:0] wbits;
    logic [DATA_W-1:0]  rd_next;

    assign dec   = pmu_decode(addr);
    assign wbits = wdata[NUM_CNT-1:0];

    always_comb begin
        clr_all = wr_en && (dec.region == RG_CTRL) && wdata[CTRL_CLR_BIT];
        w1c     = (wr_en && (dec.region == RG_OVF)) ? wbits : '0;
        for (int n = 0; n < NUM_CNT; n++) begin
            load[n] = wr_en && (dec.region == RG_VAL) && (dec.idx == IDX_W'(n));
        end
    end

    always_comb begin
        rd_next = '0;
        case (dec.region)
            RG_CTRL:  rd_next[CTRL_EN_BIT] = glob_en;
            RG_CFG: begin
                rd_next[7:0]                    = 8'(NUM_CNT);
                rd_next[CFG_GRP_LSB +: 8]       = 8'(NUM_GRP);
            end
            RG_ENSET, RG_ENCLR: rd_next[NUM_CNT-1:0] = cnt_en;
            RG_IESET, RG_IECLR: rd_next[NUM_CNT-1:0] = int_en;
            RG_OVF:   rd_next[NUM_CNT-1:0] = ovf;
            RG_GRP: begin
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (dec.idx == IDX_W'(g)) begin
                        rd_next[GRP_EN_BIT]         = grp_en[g];
                        rd_next[GRP_CNT_LSB +: 4]   = 4'(PER_GRP);
                    end
                end
            end
            RG_SEL: begin
                for (int n = 0; n < NUM_CNT; n++) begin
                    if (dec.idx == IDX_W'(n)) rd_next[SEL_W-1:0] = evsel[n];
                end
            end
            RG_VAL: begin
                for (int n = 0; n < NUM_CNT; n++) begin
                    if (dec.idx == IDX_W'(n)) rd_next[CNT_W-1:0] = cnt_val[n];
                end
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
            grp_en  <= '0;
            cnt_en  <= '0;
            int_en  <= '0;
            ovf     <= '0;
            evsel   <= '0;
            rdata   <= '0;
        end else begin
            if (wr_en) begin
                case (dec.region)
                    RG_CTRL:  glob_en <= wdata[CTRL_EN_BIT];
                    RG_ENSET: cnt_en  <= cnt_en | wbits;
                    RG_ENCLR: cnt_en  <= cnt_en & ~wbits;
                    RG_IESET: int_en  <= int_en | wbits;
                    RG_IECLR: int_en  <= int_en & ~wbits;
                    RG_GRP: begin
                        for (int g = 0; g < NUM_GRP; g++) begin
                            if (dec.idx == IDX_W'(g)) grp_en[g] <= wdata[GRP_EN_BIT];
                        end
                    end
                    RG_SEL: begin
                        for (int n = 0; n < NUM_CNT; n++) begin
                            if (dec.idx == IDX_W'(n)) evsel[n] <= wdata[SEL_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
            ovf <= (ovf & ~w1c) | wrap;
            if (rd_en) rdata <= rd_next;
        end
    end
endmodule

// File: rtl/pmu_evt_bank.sv
module pmu_evt_bank
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int NUM_GRP = 2,
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    localparam int PER_GRP = NUM_CNT / NUM_GRP;
    localparam int SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic                          glob_en;
    logic [NUM_GRP-1:0]            grp_en;
    logic [NUM_CNT-1:0]            cnt_en;
    logic [NUM_CNT-1:0]            int_en;
    logic [NUM_CNT-1:0]            ovf;
    logic [NUM_CNT-1:0][SEL_W-1:0] evsel;
    logic                          clr_all;
    logic [NUM_CNT-1:0]            load;
    logic [NUM_CNT-1:0]            wrap;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

    pmu_regs #(
        .NUM_CNT(NUM_CNT), .NUM_GRP(NUM_GRP), .CNT_W(CNT_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .cnt_val(cnt_val), .wrap(wrap),
        .rdata(bus_rdata), .glob_en(glob_en), .grp_en(grp_en),
        .cnt_en(cnt_en), .int_en(int_en), .ovf(ovf), .evsel(evsel),
        .clr_all(clr_all), .load(load)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam int GI = i / PER_GRP;
        logic on;
        assign on = glob_en && grp_en[GI] && cnt_en[i];

        pmu_counter #(
            .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)
        ) u_cnt (
            .clk(clk), .rst(rst), .active(on), .sel(evsel[i]), .evt(evt_in),
            .clr(clr_all), .load(load[i]), .load_val(bus_wdata[CNT_W-1:0]),
            .value(cnt_val[i]), .wrap(wrap[i])
        );
    end

    assign irq = |(ovf & int_en);
endmodule

// File: rtl/pmu_evt_bank_chk.sv
module pmu_evt_bank_chk #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_wr,
    input logic                          irq,
    input logic                          glob_en,
    input logic [NUM_CNT-1:0]            cnt_en,
    input logic [NUM_CNT-1:0]            int_en,
    input logic [NUM_CNT-1:0]            ovf,
    input logic [NUM_CNT-1:0]            wrap,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val
);
    logic started;

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (int_en != '0));

    a_r8_irq_on_enabled_ovf: assert property (@(posedge clk) disable iff (rst)
        ((ovf & int_en) != '0) |-> irq);

    a_r7_ovf_rises_from_wrap: assert property (@(posedge clk) disable iff (rst)
        started |-> ((ovf & ~$past(ovf) & ~$past(wrap)) == '0));

    a_r9_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        started |-> (($past(wrap) & ~ovf) == '0));

    a_r2_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
        (started && !$past(glob_en) && !$past(bus_wr)) |-> (cnt_val == $past(cnt_val)));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_hold
        a_r4_disabled_holds: assert property (@(posedge clk) disable iff (rst)
            (started && !$past(cnt_en[i]) && !$past(bus_wr)) |-> (cnt_val[i] == $past(cnt_val[i])));
    end
endmodule

bind pmu_evt_bank pmu_evt_bank_chk #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .irq(irq), .glob_en(glob_en),
    .cnt_en(cnt_en), .int_en(int_en), .ovf(ovf), .wrap(wrap), .cnt_val(cnt_val)
);

// File: tb/tb_pmu_evt_bank.sv
`timescale 1ns/1ps
module tb_pmu_evt_bank;
    localparam int NC = 8;
    localparam int NG = 2;
    localparam int PG = NC / NG;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_in = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_cnt [NC];
    logic [NC-1:0] m_en, m_ie, m_ovf;
    logic [NG-1:0] m_grp;
    logic [3:0]  m_sel [NC];
    logic        m_glob;

    always #10 clk = ~clk;

    pmu_evt_bank dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int n = 0; n < NC; n++) begin
            m_cnt[n] = '0;
            m_sel[n] = '0;
        end
        m_en = '0; m_ie = '0; m_ovf = '0; m_grp = '0; m_glob = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 12'h000) v[0] = m_glob;
        else if (a == 12'h004) v = {8'(NG), 16'h0, 8'(NC)};
        else if (a == 12'h010 || a == 12'h014) v[NC-1:0] = m_en;
        else if (a == 12'h018 || a == 12'h01C) v[NC-1:0] = m_ie;
        else if (a == 12'h020) v[NC-1:0] = m_ovf;
        else if (a[11:8] == 4'h1 && int'(a[7:2]) < NG) begin
            v[11] = m_grp[a[7:2]];
            v[27:24] = 4'(PG);
        end
        else if (a[11:8] == 4'h2 && int'(a[7:2]) < NC) v[3:0] = m_sel[a[7:2]];
        else if (a[11:8] == 4'h3 && int'(a[7:2]) < NC) v = m_cnt[a[7:2]];
        return v;
    endfunction

    task automatic model_edge(input logic w, input logic [11:0] a, input logic [31:0] d,
                              input logic [15:0] e);
        logic [NC-1:0] wr_bits;
        logic [NC-1:0] w1c;
        logic on;
        wr_bits = '0;
        for (int n = 0; n < NC; n++) begin
            on = m_glob && m_grp[n / PG] && m_en[n];
            if (w && a == 12'h000 && d[1]) m_cnt[n] = '0;
            else if (w && a == 12'(12'h300 + 4 * n)) m_cnt[n] = d;
            else if (on && e[m_sel[n]]) begin
                if (m_cnt[n] == 32'hFFFF_FFFF) wr_bits[n] = 1'b1;
                m_cnt[n] = m_cnt[n] + 1;
            end
        end
        w1c = (w && a == 12'h020) ? d[NC-1:0] : '0;
        m_ovf = (m_ovf & ~w1c) | wr_bits;
        if (w) begin
            if (a == 12'h000) m_glob = d[0];
            else if (a == 12'h010) m_en = m_en | d[NC-1:0];
            else if (a == 12'h014) m_en = m_en & ~d[NC-1:0];
            else if (a == 12'h018) m_ie = m_ie | d[NC-1:0];
            else if (a == 12'h01C) m_ie = m_ie & ~d[NC-1:0];
            else if (a[11:8] == 4'h1 && int'(a[7:2]) < NG) m_grp[a[7:2]] = d[11];
            else if (a[11:8] == 4'h2 && int'(a[7:2]) < NC) m_sel[a[7:2]] = d[3:0];
        end
    endtask

    task automatic cycle(input logic w, input logic r, input logic [11:0] a,
                         input logic [31:0] d, input logic [15:0] e);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; evt_in = e;
        @(posedge clk);
        model_edge(w, a, d, e);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; evt_in = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cycle(1'b1, 1'b0, a, d, 16'h0);
    endtask

    task automatic ev(input logic [15:0] e);
        cycle(1'b0, 1'b0, 12'h0, 32'h0, e);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a);
        logic [31:0] exp;
        exp = model_read(a);
        cycle(1'b0, 1'b1, a, 32'h0, 16'h0);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string tag);
        chk(tag, {31'h0, irq}, {31'h0, |(m_ovf & m_ie)});
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 ctrl", 12'h000);
        rd_chk("R1 cnten", 12'h010);
        rd_chk("R1 inten", 12'h018);
        rd_chk("R1 ovf", 12'h020);
        rd_chk("R1 counter0", 12'h300);
        rd_chk("R1 counter7", 12'h31C);
        irq_chk("R1 irq");

        // R10 configuration words
        chk("R10 cfg model", model_read(12'h004), 32'h0200_0008);
        rd_chk("R10 cfg", 12'h004);
        rd_chk("R10 grp0", 12'h100);
        rd_chk("R10 grp1", 12'h104);

        // R11 load and read back
        wr(12'h314, 32'h1234_ABCD);
        rd_chk("R11 counter5", 12'h314);
        wr(12'h314, 32'h0);

        // Setup: selector n = n, all on
        for (int n = 0; n < NC; n++) wr(12'(12'h200 + 4 * n), 32'(n));
        rd_chk("R5 sel3", 12'h20C);
        wr(12'h010, 32'hFF);
        wr(12'h100, 32'h800);
        wr(12'h104, 32'h800);
        wr(12'h000, 32'h1);
        ev(16'h00FF); ev(16'h0005); ev(16'h0080); ev(16'h00F0);
        for (int n = 0; n < NC; n++) rd_chk("R5 count", 12'(12'h300 + 4 * n));

        // R4 clear enable of counter1, set/clear rules
        wr(12'h014, 32'h02);
        rd_chk("R4 enclr", 12'h014);
        ev(16'hFFFF);
        rd_chk("R4 counter1 held", 12'h304);
        rd_chk("R4 counter0 moved", 12'h300);
        wr(12'h010, 32'h00);
        rd_chk("R4 zero bits keep", 12'h010);
        wr(12'h010, 32'h02);
        rd_chk("R4 enset", 12'h010);

        // R3 group 1 off
        wr(12'h104, 32'h0);
        rd_chk("R3 grp1 off", 12'h104);
        ev(16'hFFFF); ev(16'hFFFF);
        rd_chk("R3 counter5 held", 12'h314);
        rd_chk("R3 counter2 moved", 12'h308);
        wr(12'h104, 32'h800);

        // R2 global off
        wr(12'h000, 32'h0);
        ev(16'hFFFF); ev(16'hFFFF);
        rd_chk("R2 counter0 held", 12'h300);
        rd_chk("R2 counter6 held", 12'h318);
        wr(12'h000, 32'h1);

        // R6 clear all counters
        ev(16'hFFFF);
        wr(12'h000, 32'h3);
        rd_chk("R6 counter0 zero", 12'h300);
        rd_chk("R6 counter7 zero", 12'h31C);
        rd_chk("R6 ctrl reads en only", 12'h000);

        // R7 wrap sets overflow, R8 interrupt
        wr(12'h308, 32'hFFFF_FFFE);
        ev(16'h0004);
        rd_chk("R7 counter2 all ones", 12'h308);
        irq_chk("R8 no ovf yet");
        ev(16'h0004);
        rd_chk("R7 counter2 wrapped", 12'h308);
        rd_chk("R7 ovf set", 12'h020);
        irq_chk("R8 ovf without enable");
        wr(12'h018, 32'h04);
        irq_chk("R8 irq raised");
        wr(12'h020, 32'h01);
        rd_chk("R7 w1c other bit keeps", 12'h020);
        irq_chk("R8 irq still high");
        wr(12'h020, 32'h04);
        rd_chk("R7 w1c cleared", 12'h020);
        irq_chk("R8 irq dropped");

        // R9 wrap and clear in one cycle
        wr(12'h308, 32'hFFFF_FFFF);
        cycle(1'b1, 1'b0, 12'h020, 32'h04, 16'h0004);
        rd_chk("R9 ovf kept", 12'h020);
        irq_chk("R9 irq high");
        wr(12'h020, 32'h04);
        wr(12'h01C, 32'h04);
        rd_chk("R8 ieclr", 12'h01C);

        // Random phase (R4 R5 R3 R2)
        for (int it = 0; it < 600; it++) begin
            int unsigned op;
            op = $urandom % 10;
            case (op)
                0: wr(12'h010, 32'($urandom % 256));
                1: wr(12'h014, 32'($urandom % 256));
                2: wr(12'(12'h100 + 4 * ($urandom % NG)), (($urandom % 2) == 1) ? 32'h800 : 32'h0);
                3: wr(12'h000, (($urandom % 4) != 0) ? 32'h1 : 32'h0);
                4: wr(12'(12'h200 + 4 * ($urandom % NC)), 32'($urandom % 16));
                5: wr(12'h018, 32'($urandom % 256));
                6, 7, 8: ev(16'($urandom));
                default: begin
                    rd_chk("R5 random counter", 12'(12'h300 + 4 * ($urandom % NC)));
                    irq_chk("R8 random irq");
                end
            endcase
        end
        for (int n = 0; n < NC; n++) rd_chk("R5 final counter", 12'(12'h300 + 4 * n));
        rd_chk("R4 final enables", 12'h010);

        summary();
        $finish;
    end
endmodule